// File: doc/BRIEF.md
# Perfect Address Filter With Setup Loader

This block decides whether an Ethernet receive frame is kept, judging by its destination address. It holds a table of sixteen exact-match 48-bit addresses. The table is written by streaming a setup frame in one byte per cycle. A receive frame then presents its six destination bytes one per cycle, first on the wire first. One cycle after the sixth byte, the block gives an accept/reject decision together with two status flags. One flag reports that filtering was bypassed. The other reports that the frame passed only because it is multicast.

Four mode inputs change the decision. They are promiscuous, receive-all, pass-all-multicast and inverse. The decision is taken by a fixed order of precedence. Broadcast is checked first. Then comes promiscuous or receive-all, then the multicast pass, and last the exact match, which the inverse mode can invert. A setup frame of the wrong length is dropped whole, so the table is never left half written.

Top module: `addr_filter`

## Requirements
- R1: After reset every table entry is zero, so before any setup load only the all-zero destination matches an entry. Also after reset `dec_valid`, `accept`, `fail_flag` and `mcast_flag` are 0.
- R2: A setup frame whose `setup_last` byte is byte number 191 (192 bytes in all) replaces the table. Entry n takes setup bytes 12n, 12n+1, 12n+4, 12n+5, 12n+8 and 12n+9 as address bytes 0 to 5, where address byte 0 is the first destination byte received.
- R3: A setup frame of any other length, shorter or longer, leaves every table entry unchanged.
- R4: A destination of all ones (FF:FF:FF:FF:FF:FF) is accepted under every mode setting, with both flags at 0.
- R5: For a non-broadcast destination, with `promisc` or `rx_all` set, the frame is accepted and `fail_flag` is 1.
- R6: For a non-broadcast destination, with neither `promisc` nor `rx_all` set, `pass_mcast` set, and bit 0 of the first destination byte at 1, the frame is accepted and `mcast_flag` is 1. When that bit is 0, the multicast pass does not apply.
- R7: In all other cases, a destination equal to any of the sixteen entries is accepted and any other destination is rejected, with both flags at 0.
- R8: With `inverse` set, the result of R7 is inverted: a match is rejected and a non-match is accepted.
- R9: Precedence runs broadcast, then promiscuous/receive-all, then pass-all-multicast, then exact match. At most one flag is set per decision.
- R10: `dec_valid` is a one-cycle pulse in the cycle after the sixth destination byte is taken. Bytes after the sixth are ignored until the next `rx_start`. `accept` and the flags are 0 whenever `dec_valid` is 0.
- R11: `rx_start` discards any partially compared destination. Bytes presented with `rx_start` high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Setup byte strobe |
| setup_byte | input | 8 | Setup frame byte |
| setup_last | input | 1 | Marks the final byte of a setup frame |
| rx_start | input | 1 | Start of a receive frame, clears compare state |
| rx_valid | input | 1 | Destination byte strobe |
| rx_byte | input | 8 | Destination byte, first received first |
| promisc | input | 1 | Promiscuous mode |
| rx_all | input | 1 | Receive-all mode |
| pass_mcast | input | 1 | Pass all multicast |
| inverse | input | 1 | Invert the exact-match result |
| dec_valid | output | 1 | Decision strobe |
| accept | output | 1 | Frame is accepted |
| fail_flag | output | 1 | Accepted with filtering bypassed |
| mcast_flag | output | 1 | Accepted through the multicast pass |

## Verification
Destinations are drawn from five classes: an exact table entry, an entry with a single bit flipped, broadcast, a random unicast address and a random multicast address. Each class is tried under random mode mixes. The near-miss class separates a real six-byte compare from a partial one. Broadcast and multicast under stacked modes expose the order of precedence. Short and long setup frames between full loads show whether an aborted load leaves the table untouched. Frames cut off by an early start, and frames with trailing bytes, exercise the clearing of compare state and the single decision pulse.

// File: rtl/addr_filter.sv
module addr_filter #(
  parameter int NUM_ENTRIES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       setup_valid,
  input  logic [7:0] setup_byte,
  input  logic       setup_last,
  input  logic       rx_start,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       promisc,
  input  logic       rx_all,
  input  logic       pass_mcast,
  input  logic       inverse,
  output logic       dec_valid,
  output logic       accept,
  output logic       fail_flag,
  output logic       mcast_flag
);
  localparam int SLOT_BYTES = 12;
  localparam int ADDR_BYTES = 6;
  localparam int SETUP_LEN  = NUM_ENTRIES * SLOT_BYTES;
  localparam int CW = $clog2(SETUP_LEN + 1);
  localparam int SW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(SETUP_LEN - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(SETUP_LEN);
  localparam logic [3:0]    LAST_OFF = 4'(SLOT_BYTES - 1);
  localparam logic [2:0]    LAST_IDX = 3'(ADDR_BYTES - 1);

  logic [47:0]   tbl    [NUM_ENTRIES];
  logic [47:0]   shadow [NUM_ENTRIES];
  logic [CW-1:0] cnt;
  logic [SW-1:0] slot;
  logic [3:0]    off;
  logic [2:0]    keep_k;

  assign keep_k = {off[3:2], off[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      slot <= '0;
      off  <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) tbl[e] <= '0;
    end else if (setup_valid) begin
      if (setup_last) begin
        if (cnt == LAST_CNT)
          for (int e = 0; e < NUM_ENTRIES; e++) tbl[e] <= shadow[e];
        cnt  <= '0;
        slot <= '0;
        off  <= '0;
      end else begin
        if (cnt != FULL_CNT) cnt <= cnt + 1'b1;
        if (off == LAST_OFF) begin
          off  <= '0;
          slot <= slot + 1'b1;
        end else begin
          off <= off + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (setup_valid && !off[1])
      shadow[slot][{keep_k, 3'b000} +: 8] <= setup_byte;

  logic [2:0]             byte_idx;
  logic [NUM_ENTRIES-1:0] hit, eq, hit_n;
  logic                   bc, mc, take, last, bc_n, pm, mcp;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign eq[e] = tbl[e][{byte_idx, 3'b000} +: 8] == rx_byte;
  end

  assign take  = rx_valid && !rx_start && (byte_idx != 3'(ADDR_BYTES));
  assign last  = take && (byte_idx == LAST_IDX);
  assign hit_n = hit & eq;
  assign bc_n  = bc && (rx_byte == 8'hFF);
  assign pm    = promisc | rx_all;
  assign mcp   = pass_mcast & mc;

  always_ff @(posedge clk) begin
    if (!rst_n || rx_start) begin
      byte_idx <= '0;
      hit      <= '1;
      bc       <= 1'b1;
      mc       <= 1'b0;
    end else if (take) begin
      byte_idx <= byte_idx + 1'b1;
      hit      <= hit_n;
      bc       <= bc_n;
      if (byte_idx == 3'd0) mc <= rx_byte[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      accept     <= 1'b0;
      fail_flag  <= 1'b0;
      mcast_flag <= 1'b0;
    end else begin
      dec_valid  <= last;
      accept     <= last && (bc_n || pm || mcp || ((|hit_n) ^ inverse));
      fail_flag  <= last && !bc_n && pm;
      mcast_flag <= last && !bc_n && !pm && mcp;
    end
  end
endmodule

module addr_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_start,
  input logic       rx_valid,
  input logic [2:0] byte_idx,
  input logic       dec_valid,
  input logic       accept,
  input logic       fail_flag,
  input logic       mcast_flag
);
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  // R10
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || fail_flag || mcast_flag) |-> dec_valid);
  // R10
  sixth_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(rx_valid && !rx_start && byte_idx == 3'd5));
  // R9
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_flag && mcast_flag));
  // R5
  fail_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag |-> accept);
  // R6
  mcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcast_flag |-> accept);
  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> (byte_idx == 3'd0 && !dec_valid));
endmodule

bind addr_filter addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
  .byte_idx(byte_idx), .dec_valid(dec_valid), .accept(accept),
  .fail_flag(fail_flag), .mcast_flag(mcast_flag)
);

// File: tb/test_addr_filter.sv
module test_addr_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic setup_valid = 0, setup_last = 0, rx_start = 0, rx_valid = 0;
  logic [7:0] setup_byte = 0, rx_byte = 0;
  logic promisc = 0, rx_all = 0, pass_mcast = 0, inverse = 0;
  logic dec_valid, accept, fail_flag, mcast_flag;

  always #10 clk = ~clk;

  addr_filter i_addr_filter (.*);

  int tests = 0, fails = 0;
  logic [47:0] mtab [16];
  logic [7:0]  sbuf [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input logic [47:0] a, input bit pr,
                                       input bit ra, input bit pm, input bit inv);
    bit hit = 0;
    for (int e = 0; e < 16; e++) if (mtab[e] == a) hit = 1;
    if (a == 48'hFFFF_FFFF_FFFF) return 3'b100;
    if (pr || ra) return 3'b110;
    if (pm && a[0]) return 3'b101;
    return {hit ^ inv, 2'b00};
  endfunction

  function automatic string tag(input logic [47:0] a, input bit pr,
                                input bit ra, input bit pm, input bit inv);
    if (a == 48'hFFFF_FFFF_FFFF) return "R4";
    if (pr || ra) return (pm && a[0]) ? "R9" : "R5";
    if (pm && a[0]) return "R6";
    if (inv) return "R8";
    return "R7";
  endfunction

  task automatic send_setup(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      setup_valid = 1; setup_byte = sbuf[i]; setup_last = (i == len - 1);
    end
    @(negedge clk);
    setup_valid = 0; setup_last = 0;
    if (len == 192)
      for (int n = 0; n < 16; n++)
        for (int k = 0; k < 6; k++)
          mtab[n][8*k +: 8] = sbuf[12*n + (k/2)*4 + (k%2)];
  endtask

  task automatic frame(input logic [47:0] a, input bit pr, input bit ra,
                       input bit pm, input bit inv, input int extra,
                       input string force_tag);
    logic [2:0] e;
    string t;
    e = model(a, pr, ra, pm, inv);
    t = (force_tag != "") ? force_tag : tag(a, pr, ra, pm, inv);
    @(negedge clk);
    rx_start = 1; promisc = pr; rx_all = ra; pass_mcast = pm; inverse = inv;
    @(negedge clk);
    rx_start = 0;
    for (int k = 0; k < 6; k++) begin
      rx_valid = 1; rx_byte = a[8*k +: 8];
      @(negedge clk);
      if (k < 5 && dec_valid)
        chk(0, "R10", "early dec_valid", 48'(dec_valid), 48'd0);
    end
    rx_valid = 0;
    chk(dec_valid == 1'b1, "R10", "dec_valid after sixth byte", 48'(dec_valid), 48'd1);
    chk({accept, fail_flag, mcast_flag} == e, t, $sformatf("decision for %h", a),
        48'({accept, fail_flag, mcast_flag}), 48'(e));
    for (int x = 0; x < extra; x++) begin
      rx_valid = 1; rx_byte = 8'($urandom);
      @(negedge clk);
      chk(!dec_valid && !accept, "R10", "trailing byte decision",
          48'({dec_valid, accept}), 48'd0);
    end
    rx_valid = 0;
    @(negedge clk);
    chk(!dec_valid && !accept && !fail_flag && !mcast_flag, "R10",
        "outputs idle after pulse",
        48'({dec_valid, accept, fail_flag, mcast_flag}), 48'd0);
  endtask

  function automatic logic [47:0] entry_of(input int n);
    logic [47:0] r;
    for (int k = 0; k < 6; k++) r[8*k +: 8] = sbuf[12*n + (k/2)*4 + (k%2)];
    return r;
  endfunction

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [47:0] a, newa, olda;
    void'($urandom(32'd2024));
    for (int e = 0; e < 16; e++) mtab[e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({dec_valid, accept, fail_flag, mcast_flag} == 4'b0, "R1", "reset outputs",
        48'({dec_valid, accept, fail_flag, mcast_flag}), 48'd0);
    frame(48'h0100_0000_0002, 0, 0, 0, 0, 0, "R1");
    frame(48'h0, 0, 0, 0, 0, 0, "R1");

    for (int i = 0; i < 192; i++) sbuf[i] = 8'($urandom);
    sbuf[0] = sbuf[0] & 8'hFE;
    send_setup(192);
    for (int n = 0; n < 16; n++) frame(mtab[n], 0, 0, 0, 0, 0, "R2");
    frame(48'h0, 0, 0, 0, 0, 0, "R2");

    olda = mtab[3];
    for (int i = 0; i < 200; i++) sbuf[i] = 8'($urandom);
    newa = entry_of(3);
    send_setup(100);
    frame(olda, 0, 0, 0, 0, 0, "R3");
    frame(newa, 0, 0, 0, 0, 0, "R3");
    send_setup(200);
    frame(olda, 0, 0, 0, 0, 0, "R3");
    frame(newa, 0, 0, 0, 0, 0, "R3");
    send_setup(192);
    frame(newa, 0, 0, 0, 0, 0, "R2");

    frame(48'hFFFF_FFFF_FFFF, 0, 0, 0, 1, 0, "R4");
    frame(48'hFFFF_FFFF_FFFF, 1, 1, 1, 1, 0, "R4");
    frame(48'h0504_0302_0100, 1, 0, 0, 0, 0, "R5");
    frame(48'h0504_0302_0100, 0, 1, 0, 1, 0, "R5");
    frame(48'h0504_0302_0101, 0, 0, 1, 0, 0, "R6");
    frame(48'h0504_0302_0100, 0, 0, 1, 0, 0, "R6");
    frame(mtab[7], 0, 0, 0, 1, 0, "R8");
    frame(48'h0504_0302_0100, 0, 0, 0, 1, 0, "R8");
    frame(48'h0504_0302_0101, 1, 0, 1, 0, 0, "R9");
    frame(48'h0504_0302_0101, 0, 0, 1, 1, 0, "R9");
    frame(mtab[2], 0, 0, 0, 0, 4, "R10");

    @(negedge clk);
    rx_start = 1; promisc = 0; rx_all = 0; pass_mcast = 0; inverse = 0;
    @(negedge clk);
    rx_start = 0;
    for (int k = 0; k < 3; k++) begin
      rx_valid = 1; rx_byte = 8'hA5; @(negedge clk);
    end
    rx_valid = 0;
    frame(mtab[9], 0, 0, 0, 0, 0, "R11");

    for (int it = 0; it < 400; it++) begin
      int c;
      c = $urandom_range(0, 4);
      case (c)
        0: a = mtab[$urandom_range(0, 15)];
        1: a = 48'hFFFF_FFFF_FFFF;
        2: a = {16'($urandom), 32'($urandom)} & ~48'h1;
        3: a = {16'($urandom), 32'($urandom)} | 48'h1;
        default: begin
          a = mtab[$urandom_range(0, 15)];
          a[$urandom_range(0, 47)] ^= 1'b1;
        end
      endcase
      frame(a, ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
            ($urandom_range(0, 2) == 0), ($urandom_range(0, 3) == 0),
            $urandom_range(0, 2), "");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule